// File: doc/BRIEF.md
# AUX Request Framer and Reply Parser

This block sits between a transaction source and the serial side of an auxiliary display channel. On the request side it takes one transaction: a 4-bit command, a 20-bit address, a transfer length of 0 to 16 bytes and up to 16 bytes of write data. It produces the bytes to send, one per handshake, and also gives the total number of bytes in the frame. The frame always starts with a packed 3-byte header. A length byte follows the header only when the length is nonzero. Write payload comes last, and only for write commands.

On the reply side the block collects a received byte stream into a small buffer. When the receiver signals that the reply is complete, it supplies the received byte count, the size the caller expects and the hot-plug state. The block then gives a single-cycle verdict: the reply code, which comes from the upper nibble of the first byte, a status code, the number of payload bytes and the payload itself. Any payload lanes beyond the byte count are zero.

The two halves are independent and can run at the same time. Line coding, electrical signalling and channel arbitration are handled elsewhere.

Top module: `aux_frame_codec`

## Requirements
- R1: Frame byte 0 is {command, address[19:16]}, byte 1 is address[15:8] and byte 2 is address[7:0].
- R2: When the length is nonzero, frame byte 3 is length minus 1. When the length is zero, no length byte is sent.
- R3: `tx_count` is 3 for a zero length and 4 otherwise. For write commands the length is added to this. The write commands are 4'b1000 (native write), 4'b0000 (I2C write) and 4'b0100 (I2C write, middle of transaction). For writes, the payload bytes follow the header in order, from the lowest byte of `req_wdata` upward.
- R4: Any other command, for example native read 4'b1001 or I2C read 4'b0001 and 4'b0101, sends the header only.
- R5: A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high only while no frame is pending. `tx_data` holds steady while `tx_valid` is high and `tx_ready` is low. `tx_last` marks the final byte. In the cycle after the final handshake, `tx_valid` is low and `req_ready` is high.
- R6: `rep_valid` pulses for one cycle, in the cycle after `rx_done` is sampled high. `rep_code` is then the upper nibble of the first received byte.
- R7: A received count of zero gives status 2'd1 (empty) with `rep_code` 0 and `rep_nbytes` 0.
- R8: With code 0 (ACK), status is 2'd0 and `rep_nbytes` is the count minus 1. The payload is the received bytes 2 onward, in lane order, and unused lanes are zero. A nonzero code gives status 2'd0 and `rep_nbytes` 0.
- R9: An ACK whose count minus 1 exceeds `rx_size` gives status 2'd2 (overflow), with `rep_nbytes` 0 and all payload lanes zero.
- R10: When `rx_hpd_lost` is high at `rx_done`, the status is 2'd3 (disconnected), with code 0 and `rep_nbytes` 0. This check takes precedence over all others.
- R11: After reset, `tx_valid` and `rep_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Framer idle, request accepted this cycle if offered |
| req_cmd | input | 4 | Command nibble |
| req_addr | input | 20 | Target address |
| req_len | input | 5 | Transfer length, 0 to 16 |
| req_wdata | input | 128 | Write payload, byte i at bits 8i+7:8i |
| tx_valid | output | 1 | Frame byte available |
| tx_ready | input | 1 | Sink takes the byte |
| tx_data | output | 8 | Current frame byte |
| tx_last | output | 1 | Current byte is the final one |
| tx_count | output | 5 | Bytes in the pending frame |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_done | input | 1 | Reply complete, evaluate now |
| rx_count | input | 5 | Number of bytes received |
| rx_size | input | 5 | Largest payload the caller accepts |
| rx_hpd_lost | input | 1 | Hot-plug disconnected |
| rep_valid | output | 1 | Verdict pulse |
| rep_code | output | 4 | Reply code |
| rep_status | output | 2 | 0 ok, 1 empty, 2 overflow, 3 disconnected |
| rep_nbytes | output | 5 | Payload bytes returned |
| rep_data | output | 128 | Payload, byte i at bits 8i+7:8i |

## Verification
An accepted request shows its first byte and `tx_count` in the very next cycle, because one register stage lies between `req_valid` and `tx_valid`. Each later byte appears one cycle after the handshake that retires the previous one. The bench therefore compares the byte in each cycle against its expected position index. This index advances only on cycles where the bench raised `tx_ready`, and stalls are inserted at random. The reply verdict is registered, so it is due exactly one cycle after `rx_done`. The bench samples it there and then confirms that `rep_valid` has dropped one cycle later. All samples are taken at the falling edge, half a cycle clear of the register updates.

// File: rtl/aux_codec_pkg.sv
package aux_codec_pkg;

    localparam int AUX_ADDR_W   = 20;
    localparam int AUX_HDR_BASE = 3;
    localparam int AUX_HDR_MAX  = 4;

    localparam logic [3:0] CMD_NATIVE_WR = 4'b1000;
    localparam logic [3:0] CMD_NATIVE_RD = 4'b1001;
    localparam logic [3:0] CMD_I2C_WR    = 4'b0000;
    localparam logic [3:0] CMD_I2C_RD    = 4'b0001;
    localparam logic [3:0] CMD_I2C_WR_MT = 4'b0100;
    localparam logic [3:0] CMD_I2C_RD_MT = 4'b0101;

    typedef enum logic [1:0] {
        ST_OK       = 2'd0,
        ST_EMPTY    = 2'd1,
        ST_OVERFLOW = 2'd2,
        ST_UNPLUG   = 2'd3
    } aux_status_e;

    function automatic logic aux_is_write(input logic [3:0] cmd);
        return (cmd == CMD_NATIVE_WR) || (cmd == CMD_I2C_WR) || (cmd == CMD_I2C_WR_MT);
    endfunction

    function automatic int unsigned aux_hdr_bytes(input logic len_nonzero);
        return len_nonzero ? AUX_HDR_MAX : AUX_HDR_BASE;
    endfunction

endpackage

// File: rtl/aux_req_framer.sv
module aux_req_framer
    import aux_codec_pkg::*;
#(
    parameter int MAX_LEN = 16,
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int CNT_W  = $clog2(MAX_LEN + AUX_HDR_MAX + 1),
    localparam int DIDX_W = $clog2(MAX_LEN)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [3:0]              req_cmd,
    input  logic [AUX_ADDR_W-1:0]   req_addr,
    input  logic [LEN_W-1:0]        req_len,
    input  logic [MAX_LEN*8-1:0]    req_wdata,
    output logic                    tx_valid,
    input  logic                    tx_ready,
    output logic [7:0]              tx_data,
    output logic                    tx_last,
    output logic [CNT_W-1:0]        tx_count
);

    typedef struct packed {
        logic [3:0]            cmd;
        logic [AUX_ADDR_W-1:0] addr;
        logic [LEN_W-1:0]      len;
    } req_hdr_t;

    req_hdr_t             hdr_q;
    logic [MAX_LEN*8-1:0] wdata_q;
    logic [CNT_W-1:0]     idx_q;
    logic [CNT_W-1:0]     count_q;
    logic                 busy_q;

    logic [CNT_W-1:0]     next_count;
    logic [CNT_W-1:0]     hdr_n;
    logic [CNT_W-1:0]     data_pos;
    logic [DIDX_W-1:0]    dsel;
    logic [7:0]           wbytes [MAX_LEN];

    // frame size of the incoming request
    always_comb begin
        next_count = CNT_W'(aux_hdr_bytes(req_len != '0));
        if (aux_is_write(req_cmd))
            next_count = next_count + CNT_W'(req_len);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            idx_q   <= '0;
            count_q <= '0;
            hdr_q   <= '0;
            wdata_q <= '0;
        end else if (!busy_q) begin
            if (req_valid) begin
                busy_q  <= 1'b1;
                idx_q   <= '0;
                count_q <= next_count;
                hdr_q   <= '{cmd: req_cmd, addr: req_addr, len: req_len};
                wdata_q <= req_wdata;
            end
        end else if (tx_ready) begin
            if (tx_last)
                busy_q <= 1'b0;
            idx_q <= idx_q + 1'b1;
        end
    end

    for (genvar g = 0; g < MAX_LEN; g++) begin : g_lane
        assign wbytes[g] = wdata_q[g*8 +: 8];
    end

    // byte selection by frame position
    always_comb begin
        hdr_n    = CNT_W'(aux_hdr_bytes(hdr_q.len != '0));
        data_pos = idx_q - hdr_n;
        dsel     = data_pos[DIDX_W-1:0];
        if (idx_q == CNT_W'(0))
            tx_data = {hdr_q.cmd, hdr_q.addr[19:16]};
        else if (idx_q == CNT_W'(1))
            tx_data = hdr_q.addr[15:8];
        else if (idx_q == CNT_W'(2))
            tx_data = hdr_q.addr[7:0];
        else if (idx_q == CNT_W'(3) && hdr_q.len != '0)
            tx_data = 8'(hdr_q.len - 1'b1);
        else
            tx_data = wbytes[dsel];
    end

    assign req_ready = !busy_q;
    assign tx_valid  = busy_q;
    assign tx_last   = busy_q && (idx_q == count_q - 1'b1);
    assign tx_count  = count_q;

    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    assert_last_ends_R5: assert property (@(posedge clk) disable iff (rst)
        tx_valid && tx_ready && tx_last |=> !tx_valid && req_ready);

    assert_count_range_R3: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (tx_count >= CNT_W'(AUX_HDR_BASE)) && (tx_count <= CNT_W'(MAX_LEN + AUX_HDR_MAX)));

    assert_read_header_only_R4: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !aux_is_write(hdr_q.cmd) |-> tx_count <= CNT_W'(AUX_HDR_MAX));

endmodule

// File: rtl/aux_rep_parser.sv
module aux_rep_parser
    import aux_codec_pkg::*;
#(
    parameter int MAX_LEN = 16,
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int CNT_W  = $clog2(MAX_LEN + AUX_HDR_MAX + 1),
    localparam int WP_W   = $clog2(MAX_LEN + 2),
    localparam int DIDX_W = $clog2(MAX_LEN)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_valid,
    input  logic [7:0]           rx_data,
    input  logic                 rx_done,
    input  logic [CNT_W-1:0]     rx_count,
    input  logic [LEN_W-1:0]     rx_size,
    input  logic                 rx_hpd_lost,
    output logic                 rep_valid,
    output logic [3:0]           rep_code,
    output aux_status_e          rep_status,
    output logic [LEN_W-1:0]     rep_nbytes,
    output logic [MAX_LEN*8-1:0] rep_data
);

    logic [WP_W-1:0]      wptr_q;
    logic [3:0]           code_q;
    logic [7:0]           dbuf_q [MAX_LEN];
    logic [WP_W-1:0]      wslot;

    aux_status_e          st_d;
    logic [3:0]           code_d;
    logic [LEN_W-1:0]     n_d;
    logic [CNT_W-1:0]     data_cnt;
    logic [MAX_LEN*8-1:0] data_d;

    // capture: first byte keeps only its code nibble, the rest fill lanes
    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            code_q <= '0;
            for (int i = 0; i < MAX_LEN; i++) dbuf_q[i] <= '0;
        end else if (rx_done) begin
            wptr_q <= '0;
        end else if (rx_valid && wptr_q <= WP_W'(MAX_LEN)) begin
            if (wptr_q == '0)
                code_q <= rx_data[7:4];
            else
                dbuf_q[wslot[DIDX_W-1:0]] <= rx_data;
            wptr_q <= wptr_q + 1'b1;
        end
    end

    assign wslot = wptr_q - 1'b1;

    // verdict, priority: unplug, empty, non-ack, overflow
    always_comb begin
        data_cnt = rx_count - 1'b1;
        st_d     = ST_OK;
        code_d   = code_q;
        n_d      = '0;
        if (rx_hpd_lost) begin
            st_d   = ST_UNPLUG;
            code_d = '0;
        end else if (rx_count == '0) begin
            st_d   = ST_EMPTY;
            code_d = '0;
        end else if (code_q != 4'd0) begin
            st_d   = ST_OK;
        end else if (data_cnt > CNT_W'(rx_size)) begin
            st_d   = ST_OVERFLOW;
        end else begin
            n_d    = LEN_W'(data_cnt);
        end
        for (int j = 0; j < MAX_LEN; j++)
            data_d[j*8 +: 8] = (LEN_W'(j) < n_d) ? dbuf_q[j] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rep_valid  <= 1'b0;
            rep_code   <= '0;
            rep_status <= ST_OK;
            rep_nbytes <= '0;
            rep_data   <= '0;
        end else begin
            rep_valid <= rx_done;
            if (rx_done) begin
                rep_code   <= code_d;
                rep_status <= st_d;
                rep_nbytes <= n_d;
                rep_data   <= data_d;
            end
        end
    end

    assert_verdict_timing_R6: assert property (@(posedge clk) disable iff (rst)
        rep_valid |-> $past(rx_done));

    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (rst)
        rep_valid && !rx_done |=> !rep_valid);

    assert_error_no_payload_R9: assert property (@(posedge clk) disable iff (rst)
        rep_valid && rep_status != ST_OK |-> rep_nbytes == '0);

    assert_payload_bound_R8: assert property (@(posedge clk) disable iff (rst)
        rep_valid |-> rep_nbytes <= $past(rx_size));

    assert_unplug_code_R10: assert property (@(posedge clk) disable iff (rst)
        rep_valid && rep_status == ST_UNPLUG |-> rep_code == 4'd0);

endmodule

// File: rtl/aux_frame_codec.sv
module aux_frame_codec
    import aux_codec_pkg::*;
#(
    parameter int MAX_LEN = 16,
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int CNT_W  = $clog2(MAX_LEN + AUX_HDR_MAX + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [3:0]            req_cmd,
    input  logic [AUX_ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]      req_len,
    input  logic [MAX_LEN*8-1:0]  req_wdata,
    output logic                  tx_valid,
    input  logic                  tx_ready,
    output logic [7:0]            tx_data,
    output logic                  tx_last,
    output logic [CNT_W-1:0]      tx_count,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_data,
    input  logic                  rx_done,
    input  logic [CNT_W-1:0]      rx_count,
    input  logic [LEN_W-1:0]      rx_size,
    input  logic                  rx_hpd_lost,
    output logic                  rep_valid,
    output logic [3:0]            rep_code,
    output logic [1:0]            rep_status,
    output logic [LEN_W-1:0]      rep_nbytes,
    output logic [MAX_LEN*8-1:0]  rep_data
);

    aux_status_e parse_status;

    aux_req_framer #(.MAX_LEN(MAX_LEN)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_cmd   (req_cmd),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .req_wdata (req_wdata),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_data   (tx_data),
        .tx_last   (tx_last),
        .tx_count  (tx_count)
    );

    aux_rep_parser #(.MAX_LEN(MAX_LEN)) u_parser (
        .clk         (clk),
        .rst         (rst),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .rx_done     (rx_done),
        .rx_count    (rx_count),
        .rx_size     (rx_size),
        .rx_hpd_lost (rx_hpd_lost),
        .rep_valid   (rep_valid),
        .rep_code    (rep_code),
        .rep_status  (parse_status),
        .rep_nbytes  (rep_nbytes),
        .rep_data    (rep_data)
    );

    assign rep_status = parse_status;

endmodule

// File: tb/sim_aux_frame_codec.sv
`timescale 1ns/1ps
module sim_aux_frame_codec;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [3:0]   req_cmd = '0;
    logic [19:0]  req_addr = '0;
    logic [4:0]   req_len = '0;
    logic [127:0] req_wdata = '0;
    logic         tx_valid;
    logic         tx_ready = 1'b0;
    logic [7:0]   tx_data;
    logic         tx_last;
    logic [4:0]   tx_count;
    logic         rx_valid = 1'b0;
    logic [7:0]   rx_data = '0;
    logic         rx_done = 1'b0;
    logic [4:0]   rx_count = '0;
    logic [4:0]   rx_size = '0;
    logic         rx_hpd_lost = 1'b0;
    logic         rep_valid;
    logic [3:0]   rep_code;
    logic [1:0]   rep_status;
    logic [4:0]   rep_nbytes;
    logic [127:0] rep_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    aux_frame_codec u0 (.*);

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    function automatic bit is_wr(input logic [3:0] c);
        return c == 4'b1000 || c == 4'b0000 || c == 4'b0100;
    endfunction

    function automatic int frame_len(input logic [3:0] c, input int len);
        int n = (len != 0) ? 4 : 3;
        if (is_wr(c)) n += len;
        return n;
    endfunction

    function automatic logic [7:0] frame_byte(input logic [3:0] c, input logic [19:0] a,
                                              input int len, input logic [127:0] wd, input int k);
        int h = (len != 0) ? 4 : 3;
        if (k == 0) return {c, a[19:16]};
        if (k == 1) return a[15:8];
        if (k == 2) return a[7:0];
        if (k == 3 && len != 0) return 8'(len - 1);
        return wd[(k - h)*8 +: 8];
    endfunction

    task automatic run_req(input logic [3:0] c, input logic [19:0] a, input int len,
                           input logic [127:0] wd, input bit stall);
        int n = frame_len(c, len);
        int k = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R5", "idle ready", req_ready, 1);
        req_cmd = c; req_addr = a; req_len = 5'(len); req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(tx_valid == 1'b1, "R5", "valid after accept", tx_valid, 1);
        chk(tx_count == 5'(n), is_wr(c) ? "R3" : "R4", "tx_count", tx_count, n);
        chk(req_ready == 1'b0, "R5", "ready while busy", req_ready, 0);
        while (k < n) begin
            logic [7:0] e = frame_byte(c, a, len, wd, k);
            bit rdy;
            chk(tx_data == e, (k < 3) ? "R1" : ((k == 3 && len != 0) ? "R2" : "R3"),
                "frame byte", tx_data, e);
            chk(tx_last == (k == n - 1), "R5", "tx_last", tx_last, (k == n - 1));
            rdy = stall ? 1'($urandom % 2) : 1'b1;
            tx_ready = rdy;
            @(negedge clk);
            if (rdy) k++;
        end
        tx_ready = 1'b0;
        chk(tx_valid == 1'b0, is_wr(c) ? "R5" : "R4", "valid after last", tx_valid, 0);
        chk(req_ready == 1'b1, "R5", "ready after last", req_ready, 1);
    endtask

    task automatic run_rep(input logic [167:0] bytes, input int nsend, input int cnt,
                           input int size, input bit hpd);
        logic [3:0]   e_code;
        logic [1:0]   e_st;
        int           e_n;
        logic [127:0] e_data;
        for (int i = 0; i < nsend; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = bytes[i*8 +: 8];
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_done = 1'b1; rx_count = 5'(cnt); rx_size = 5'(size); rx_hpd_lost = hpd;
        e_code = bytes[7:4]; e_st = 2'd0; e_n = 0;
        if (hpd) begin e_st = 2'd3; e_code = 0; end
        else if (cnt == 0) begin e_st = 2'd1; e_code = 0; end
        else if (e_code != 0) e_st = 2'd0;
        else if (cnt - 1 > size) e_st = 2'd2;
        else e_n = cnt - 1;
        e_data = '0;
        for (int j = 0; j < e_n; j++) e_data[j*8 +: 8] = bytes[(j+1)*8 +: 8];
        @(negedge clk);
        rx_done = 1'b0; rx_hpd_lost = 1'b0;
        chk(rep_valid == 1'b1, "R6", "rep_valid pulse", rep_valid, 1);
        chk(rep_code == e_code, hpd ? "R10" : "R6", "rep_code", rep_code, e_code);
        chk(rep_status == e_st, (e_st == 3) ? "R10" : (e_st == 2) ? "R9" : (e_st == 1) ? "R7" : "R8",
            "rep_status", rep_status, e_st);
        chk(rep_nbytes == 5'(e_n), (e_st == 2) ? "R9" : "R8", "rep_nbytes", rep_nbytes, e_n);
        chk(rep_data == e_data, (e_st == 2) ? "R9" : "R8", "rep_data", rep_data, e_data);
        @(negedge clk);
        chk(rep_valid == 1'b0, "R6", "single pulse", rep_valid, 0);
    endtask

    function automatic logic [127:0] rnd128();
        logic [127:0] v;
        for (int i = 0; i < 4; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [167:0] rnd168(input logic [3:0] code);
        logic [167:0] v;
        for (int i = 0; i < 6; i++) v[i*32 +: 32] = $urandom;
        v[7:4] = code;
        return v;
    endfunction

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [3:0] cmds [6] = '{4'b1000, 4'b1001, 4'b0000, 4'b0001, 4'b0100, 4'b0101};
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_valid == 1'b0, "R11", "reset tx_valid", tx_valid, 0);
        chk(req_ready == 1'b1, "R11", "reset req_ready", req_ready, 1);
        chk(rep_valid == 1'b0, "R11", "reset rep_valid", rep_valid, 0);

        // directed requests
        run_req(4'b1000, 20'hABCDE, 0, rnd128(), 1'b0);   // write, zero length: header only
        run_req(4'b1000, 20'h12345, 16, rnd128(), 1'b1);  // full write
        run_req(4'b0100, 20'h00050, 1, rnd128(), 1'b0);   // i2c write mid-transaction
        run_req(4'b1001, 20'hF0F0F, 5, rnd128(), 1'b1);   // read: header + length
        run_req(4'b0101, 20'h00001, 16, rnd128(), 1'b0);  // read, max length
        for (int i = 0; i < 20; i++)
            run_req(cmds[$urandom % 6], 20'($urandom), int'($urandom % 17), rnd128(), 1'b1);

        // directed replies
        run_rep(rnd168(4'h0), 0, 0, 4, 1'b0);     // empty
        run_rep(rnd168(4'h0), 5, 5, 3, 1'b1);     // unplugged
        run_rep(rnd168(4'h0), 6, 6, 4, 1'b0);     // overflow by one
        run_rep(rnd168(4'h0), 5, 5, 4, 1'b0);     // exact fit
        run_rep(rnd168(4'h0), 17, 17, 16, 1'b0);  // max payload
        run_rep(rnd168(4'h2), 3, 3, 4, 1'b0);     // defer code, no payload
        run_rep(rnd168(4'h0), 1, 1, 0, 1'b0);     // bare ack
        for (int i = 0; i < 25; i++) begin
            int c = int'($urandom % 18);
            run_rep(rnd168(($urandom % 4 == 0) ? 4'($urandom) : 4'h0), c, c,
                    int'($urandom % 17), ($urandom % 8) == 0);
        end
        summary();
    end

endmodule